// File: doc/BRIEF.md
# Ternary Gate Network Key Generator

This block is a fixed sequential network of twenty identical ternary gates. Each gate has two trit inputs and two trit outputs. A trit is carried on two bits. The gates are joined by a hard-wired pattern. Some links are plain combinational connections. Other links pass through a one-trit register that clears on reset. The combinational links form no loop, so every gate output of a cycle settles from that cycle's input trit and the current register contents.

A trit is presented on each cycle where the valid strobe is high. The network reacts to it and produces one key trit per accepted input. Cycles without valid leave the whole network frozen, including the output. A synchronous reset clears every link register and the output.

Top module: `tgk_keygen`

## Requirements
- R1: Every gate maps its input pair (left, right) to its output pair (left, right) as follows, with 0, 1 and 2 coded 2'b00, 2'b01 and 2'b10:
  - (0,0)→(0,2)
  - (0,1)→(2,2)
  - (0,2)→(1,2)
  - (1,0)→(1,2)
  - (1,1)→(0,0)
  - (1,2)→(2,1)
  - (2,0)→(2,2)
  - (2,1)→(1,1)
  - (2,2)→(0,0)
- R2: While `rst` is high at a rising edge, `trit_out` becomes 0 and every link register becomes 0.
- R3: A registered link presents 0 in the first accepted cycle after reset. In each later accepted cycle it presents the value its source gate output had in the previous accepted cycle.
- R4: A combinational link carries its source gate output in the same cycle. All gates in one cycle are evaluated in a single pass.
- R5: `trit_in` feeds the left input of the last gate. The right input of that gate comes without delay from the left output of the gate before it. `trit_out` takes the left output of the last gate at the rising edge of an accepted cycle, so the result is visible one edge after the input.
- R6: When `in_valid` is low, `trit_out` and all link registers keep their values. Inserting idle cycles therefore leaves the sequence of accepted outputs unchanged.
- R7: After reset, the accepted inputs 0,2,2,2,2,2,2,0,2,1,0,1,1,0,0,1,1 give the outputs 1,1,0,2,1,2,1,0,1,1,2,1,0,1,2,2,1.
- R8: The code 2'b11 on `trit_in` or on any gate input is treated as trit 0. No gate output and no `trit_out` value is ever 2'b11.
- R9: For any trit stream, the output matches a behavioural model of the full fixed netlist.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `trit_in` as accepted this cycle |
| trit_in | input | 2 | Input trit (00, 01, 10; 11 read as 0) |
| trit_out | output | 2 | Registered key trit from the last accepted cycle |

## Verification
The reference vector after reset catches the following faults:
- a wrong table entry;
- a link that is swapped;
- a register placed on the wrong link;
- a register that starts at a non-zero value.

Any of these moves the key sequence within a few trits.

Idle cycles are woven into a replay of that vector. A design that advances its registers or its output without `in_valid` then shifts the sequence, and the mismatch shows up at the next accepted trit.

A replay with 2'b11 put in place of every 0 exposes a gate that does not fold the unused code back to 0. A long random stream, with idle gaps and stray 2'b11 codes, is compared with an independent model of the netlist. That comparison finds faults on paths the short vector leaves untouched.

// File: rtl/tgk_pkg.sv
package tgk_pkg;

    localparam int TRIT_W     = 2;
    localparam int NUM_GATES  = 20;
    localparam int GATE_IDX_W = $clog2(NUM_GATES);
    localparam int OUT_GATE   = NUM_GATES - 1;

    typedef logic [TRIT_W-1:0] trit_t;

    localparam trit_t T0 = 2'd0;
    localparam trit_t T1 = 2'd1;
    localparam trit_t T2 = 2'd2;

    typedef struct packed {
        trit_t left;
        trit_t right;
    } trit_pair_t;

    typedef enum logic [1:0] {
        LK_EXT    = 2'd0,
        LK_DIRECT = 2'd1,
        LK_DELAY  = 2'd2
    } link_kind_e;

    typedef struct packed {
        link_kind_e              kind;
        logic [GATE_IDX_W-1:0]   gate;
        logic                    side;   // 0 = left output, 1 = right output
    } link_t;

    // Fold the unused code onto trit 0.
    function automatic trit_t trit_clean(trit_t v);
        return (v == 2'b11) ? T0 : v;
    endfunction

    function automatic trit_pair_t gate_eval(trit_t l, trit_t r);
        trit_pair_t res;
        case ({trit_clean(l), trit_clean(r)})
            {T0, T0}: res = '{left: T0, right: T2};
            {T0, T1}: res = '{left: T2, right: T2};
            {T0, T2}: res = '{left: T1, right: T2};
            {T1, T0}: res = '{left: T1, right: T2};
            {T1, T1}: res = '{left: T0, right: T0};
            {T1, T2}: res = '{left: T2, right: T1};
            {T2, T0}: res = '{left: T2, right: T2};
            {T2, T1}: res = '{left: T1, right: T1};
            default:  res = '{left: T0, right: T0};
        endcase
        return res;
    endfunction

    function automatic link_t mk_link(link_kind_e k, int unsigned g, bit s);
        link_t x;
        x.kind = k;
        x.gate = GATE_IDX_W'(g);
        x.side = s;
        return x;
    endfunction

    // Source of input port `s` (0 = left, 1 = right) of gate `g`.
    function automatic link_t lnk_src(int unsigned g, bit s);
        link_t x;
        x = mk_link(LK_EXT, 0, 1'b0);
        case (g)
            0:  x = s ? mk_link(LK_DELAY, 13, 1'b1)  : mk_link(LK_DELAY, 12, 1'b1);
            1:  x = s ? mk_link(LK_DIRECT, 0, 1'b0)  : mk_link(LK_DELAY, 14, 1'b1);
            2:  x = s ? mk_link(LK_DELAY, 10, 1'b1)  : mk_link(LK_DELAY, 9, 1'b1);
            3:  x = s ? mk_link(LK_DELAY, 17, 1'b1)  : mk_link(LK_DIRECT, 2, 1'b0);
            4:  x = s ? mk_link(LK_DIRECT, 1, 1'b0)  : mk_link(LK_DELAY, 15, 1'b1);
            5:  x = s ? mk_link(LK_DELAY, 18, 1'b1)  : mk_link(LK_DIRECT, 3, 1'b0);
            6:  x = s ? mk_link(LK_DELAY, 11, 1'b1)  : mk_link(LK_DIRECT, 5, 1'b0);
            7:  x = s ? mk_link(LK_DELAY, 16, 1'b1)  : mk_link(LK_DELAY, 19, 1'b1);
            8:  x = s ? mk_link(LK_DIRECT, 7, 1'b1)  : mk_link(LK_DIRECT, 2, 1'b1);
            9:  x = s ? mk_link(LK_DIRECT, 3, 1'b1)  : mk_link(LK_DIRECT, 1, 1'b1);
            10: x = s ? mk_link(LK_DIRECT, 4, 1'b0)  : mk_link(LK_DIRECT, 8, 1'b1);
            11: x = s ? mk_link(LK_DIRECT, 7, 1'b0)  : mk_link(LK_DIRECT, 8, 1'b0);
            12: x = s ? mk_link(LK_DIRECT, 0, 1'b1)  : mk_link(LK_DIRECT, 6, 1'b1);
            13: x = s ? mk_link(LK_DIRECT, 4, 1'b1)  : mk_link(LK_DIRECT, 6, 1'b0);
            14: x = s ? mk_link(LK_DIRECT, 13, 1'b0) : mk_link(LK_DIRECT, 12, 1'b0);
            15: x = s ? mk_link(LK_DIRECT, 11, 1'b0) : mk_link(LK_DIRECT, 5, 1'b1);
            16: x = s ? mk_link(LK_DIRECT, 15, 1'b0) : mk_link(LK_DIRECT, 10, 1'b0);
            17: x = s ? mk_link(LK_DIRECT, 16, 1'b0) : mk_link(LK_DIRECT, 14, 1'b0);
            18: x = s ? mk_link(LK_DIRECT, 17, 1'b0) : mk_link(LK_DIRECT, 9, 1'b0);
            19: x = s ? mk_link(LK_DIRECT, 18, 1'b0) : mk_link(LK_EXT, 0, 1'b0);
            default: x = mk_link(LK_EXT, 0, 1'b0);
        endcase
        return x;
    endfunction

endpackage

// File: rtl/tgk_gate.sv
module tgk_gate
    import tgk_pkg::*;
(
    input  trit_t in_l,
    input  trit_t in_r,
    output trit_t out_l,
    output trit_t out_r
);

    trit_pair_t res;

    always_comb begin
        res   = gate_eval(in_l, in_r);
        out_l = res.left;
        out_r = res.right;
    end

endmodule

// File: rtl/tgk_delay.sv
module tgk_delay
    import tgk_pkg::*;
#(
    parameter int W = TRIT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (en) begin
            q <= d;
        end
    end

    // R3: an accepted cycle loads the source value
    a_r3_capture: assert property (@(posedge clk) disable iff (rst)
        en |=> (q == $past(d)));

    // R6: no accepted cycle, no change
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(q));

endmodule

// File: rtl/tgk_keygen.sv
module tgk_keygen
    import tgk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [TRIT_W-1:0] trit_in,
    output logic [TRIT_W-1:0] trit_out
);

    // Per-gate input and output trits, index 0 = left, 1 = right.
    trit_t gin  [NUM_GATES][2];
    trit_t gout [NUM_GATES][2];

    for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
        for (genvar s = 0; s < 2; s++) begin : g_side
            localparam link_t LK = lnk_src(g, (s == 1));
            if (LK.kind == LK_EXT) begin : g_ext
                assign gin[g][s] = trit_in;
            end else if (LK.kind == LK_DIRECT) begin : g_dir
                assign gin[g][s] = gout[LK.gate][LK.side];
            end else begin : g_dly
                tgk_delay #(.W(TRIT_W)) u_dly (
                    .clk (clk),
                    .rst (rst),
                    .en  (in_valid),
                    .d   (gout[LK.gate][LK.side]),
                    .q   (gin[g][s])
                );
            end
        end

        tgk_gate u_gate (
            .in_l  (gin[g][0]),
            .in_r  (gin[g][1]),
            .out_l (gout[g][0]),
            .out_r (gout[g][1])
        );

        // R8: a gate never emits the unused code
        a_r8_gate_legal: assert property (@(posedge clk) disable iff (rst)
            (gout[g][0] != 2'b11) && (gout[g][1] != 2'b11));

        // R1: equal non-zero inputs cancel to (0,0)
        a_r1_equal_cancel: assert property (@(posedge clk) disable iff (rst)
            ((gin[g][0] == gin[g][1]) && (gin[g][0] != T0) && (gin[g][0] != 2'b11))
            |-> ((gout[g][0] == T0) && (gout[g][1] == T0)));
    end

    // Output register of the last gate's left output.
    tgk_delay #(.W(TRIT_W)) u_out_reg (
        .clk (clk),
        .rst (rst),
        .en  (in_valid),
        .d   (gout[OUT_GATE][0]),
        .q   (trit_out)
    );

    // R6: the key trit holds on idle cycles
    a_r6_out_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(trit_out));

    // R8: the key trit is always a legal code
    a_r8_out_legal: assert property (@(posedge clk) disable iff (rst)
        trit_out != 2'b11);

endmodule

// File: tb/tgk_keygen_tb_top.sv
module tgk_keygen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N_GOLD     = 17;
    localparam int N_RAND     = 3000;
    localparam int WATCHDOG   = 150000;

    localparam int GOLD_IN  [N_GOLD] = '{0,2,2,2,2,2,2,0,2,1,0,1,1,0,0,1,1};
    localparam int GOLD_OUT [N_GOLD] = '{1,1,0,2,1,2,1,0,1,1,2,1,0,1,2,2,1};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [1:0] trit_in = 2'b00;
    logic [1:0] trit_out;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    int md [11];   // model link registers
    int prev_out;

    tgk_keygen dut_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .trit_in  (trit_in),
        .trit_out (trit_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG && !done) begin
                n_fails++;
                $display("FAIL watchdog: actual %0d cycles, expected <= %0d", cycles, WATCHDOG);
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
                $finish;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic mgate(input int a, input int b, output int x, output int y);
        int p;
        int q;
        p = (a == 3) ? 0 : a;
        q = (b == 3) ? 0 : b;
        case (p * 3 + q)
            0: begin x = 0; y = 2; end
            1: begin x = 2; y = 2; end
            2: begin x = 1; y = 2; end
            3: begin x = 1; y = 2; end
            4: begin x = 0; y = 0; end
            5: begin x = 2; y = 1; end
            6: begin x = 2; y = 2; end
            7: begin x = 1; y = 1; end
            default: begin x = 0; y = 0; end
        endcase
    endtask

    task automatic model_reset();
        for (int k = 0; k < 11; k++) md[k] = 0;
    endtask

    task automatic model_step(input int xin, output int yout);
        int ol [20];
        int orr [20];
        mgate(md[0], md[1], ol[0], orr[0]);
        mgate(md[2], ol[0], ol[1], orr[1]);
        mgate(md[3], md[4], ol[2], orr[2]);
        mgate(ol[2], md[5], ol[3], orr[3]);
        mgate(md[6], ol[1], ol[4], orr[4]);
        mgate(ol[3], md[7], ol[5], orr[5]);
        mgate(ol[5], md[8], ol[6], orr[6]);
        mgate(md[9], md[10], ol[7], orr[7]);
        mgate(orr[2], orr[7], ol[8], orr[8]);
        mgate(orr[1], orr[3], ol[9], orr[9]);
        mgate(orr[8], ol[4], ol[10], orr[10]);
        mgate(ol[8], ol[7], ol[11], orr[11]);
        mgate(orr[6], orr[0], ol[12], orr[12]);
        mgate(ol[6], orr[4], ol[13], orr[13]);
        mgate(ol[12], ol[13], ol[14], orr[14]);
        mgate(orr[5], ol[11], ol[15], orr[15]);
        mgate(ol[10], ol[15], ol[16], orr[16]);
        mgate(ol[14], ol[16], ol[17], orr[17]);
        mgate(ol[9], ol[17], ol[18], orr[18]);
        mgate(xin, ol[18], ol[19], orr[19]);
        yout = ol[19];
        md[0] = orr[12]; md[1] = orr[13]; md[2] = orr[14];
        md[3] = orr[9];  md[4] = orr[10]; md[5] = orr[17];
        md[6] = orr[15]; md[7] = orr[18]; md[8] = orr[11];
        md[9] = orr[19]; md[10] = orr[16];
    endtask

    // Drive at the falling edge, sample just after the next rising edge.
    task automatic apply(input logic v, input logic [1:0] t);
        @(negedge clk);
        in_valid = v;
        trit_in  = t;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        trit_in = 2'b00;
        repeat (2) @(posedge clk);
        #1;
        check("R2 reset output", int'(trit_out), 0);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        int mexp;
        model_reset();

        // R2: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R2 output after reset", int'(trit_out), 0);
        @(negedge clk);
        rst = 1'b0;

        // R6: idle cycles right after reset leave everything at zero
        apply(1'b0, 2'b10);
        check("R6 idle after reset", int'(trit_out), 0);
        apply(1'b0, 2'b01);
        check("R6 idle after reset", int'(trit_out), 0);

        // R7 / R1 / R3 / R4 / R5: reference vector walked from the table
        for (int i = 0; i < N_GOLD; i++) begin
            apply(1'b1, 2'(GOLD_IN[i]));
            check("R7 reference vector", int'(trit_out), GOLD_OUT[i]);
            model_step(GOLD_IN[i], mexp);
            check("R9 model on reference", int'(trit_out), mexp);
        end

        // R6 / R3: replay with idle gaps, output must hold across them
        do_reset();
        for (int i = 0; i < N_GOLD; i++) begin
            apply(1'b1, 2'(GOLD_IN[i]));
            check("R6 reference with gaps", int'(trit_out), GOLD_OUT[i]);
            prev_out = GOLD_OUT[i];
            if (i % 3 == 1) begin
                apply(1'b0, 2'(2 - GOLD_IN[i]));
                check("R6 held during gap", int'(trit_out), prev_out);
                apply(1'b0, 2'b11);
                check("R6 held during gap", int'(trit_out), prev_out);
            end
        end

        // R8: code 11 stands in for every 0 of the reference vector
        do_reset();
        for (int i = 0; i < N_GOLD; i++) begin
            apply(1'b1, (GOLD_IN[i] == 0) ? 2'b11 : 2'(GOLD_IN[i]));
            check("R8 code 11 read as 0", int'(trit_out), GOLD_OUT[i]);
        end

        // R5: first accepted trit after reset, each value
        for (int t = 0; t < 3; t++) begin
            do_reset();
            apply(1'b1, 2'(t));
            model_step(t, mexp);
            check("R5 first trit latency", int'(trit_out), mexp);
        end
        do_reset();
        apply(1'b1, 2'b00);
        check("R5 first trit of 0 gives 1", int'(trit_out), 1);

        // R9: random stream with gaps and stray 11 codes vs model
        do_reset();
        prev_out = 0;
        for (int i = 0; i < N_RAND; i++) begin
            int r;
            int x;
            logic v;
            r = $urandom_range(0, 15);
            v = (r != 0);
            x = (r == 1) ? 3 : $urandom_range(0, 2);
            apply(v, 2'(x));
            if (v) begin
                model_step(x, mexp);
                prev_out = mexp;
                check("R9 random vs model", int'(trit_out), mexp);
            end else begin
                check("R6 random idle hold", int'(trit_out), prev_out);
            end
        end

        // R2: reset mid-stream restarts the reference sequence
        apply(1'b1, 2'b10);
        do_reset();
        apply(1'b1, 2'(GOLD_IN[0]));
        check("R2 restart after reset", int'(trit_out), GOLD_OUT[0]);
        apply(1'b1, 2'(GOLD_IN[1]));
        check("R2 restart after reset", int'(trit_out), GOLD_OUT[1]);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule